// File: doc/BRIEF.md
# Carrier Frequency Offset Injector

This block sits in a transmit-to-receive test path and rotates every complex baseband sample by a steadily advancing phase. The result is a carrier frequency offset that can be programmed, so that a downstream receiver's carrier recovery can be stressed. A phase step is written through a simple register write port. A phase accumulator adds that step once for each accepted sample. The upper bits of the accumulator address a cosine/sine table, and the table output multiplies the incoming I/Q sample as a full complex product.

The offset in hertz is step × Fs / 2^16. At a 15.36 MHz sample rate one step unit is 234.375 Hz, so a step of 1024 gives +240 kHz. A negative offset is written as 65536 − |step|, and the accumulator's modulo-2^16 wrap turns the rotation the other way. The step register can only be written; it has no read path.

Top module: `cfo_rotator`

## Requirements
- R1: While rst_ni is low, the accumulator and the step register are cleared, out_valid_o is 0 and out_i_o/out_q_o are 0.
- R2: A cycle with wr_en_i high and wr_addr_i equal to 0x118 loads wr_data_i into the step register. Writes to any other address leave the step unchanged.
- R3: The 16-bit accumulator adds the step, modulo 2^16, at each clock where in_valid_i is high, and holds otherwise. A sample is rotated by the accumulator value before its own addition.
- R4: The table index is accumulator bits [15:8]. The low 8 bits have no effect on the output.
- R5: Entry k of the table is cos = round(32768·cos(2πk/256)) and sin = round(32768·sin(2πk/256)), clamped to the signed 16-bit range. This makes index 0 equal to (32767, 0).
- R6: out_i = sat((I·C − Q·S + 2^14) >>> 15) and out_q = sat((I·S + Q·C + 2^14) >>> 15), where sat clamps to [−32768, 32767].
- R7: With a step of 0, any input whose components both lie in [−16383, 16384] appears unchanged at the output.
- R8: out_valid_o equals in_valid_i delayed by exactly 2 clocks. The output data holds its last value while out_valid_o is low.
- R9: A new step applies to the addition of the next accepted sample. The accumulator is never reset by a write, so the phase stays continuous.
- R10: A step of 1024 with input (16384, 0) gives a positive out_q on the second sample. A step of 0xFC00 gives a negative out_q once the phase has wrapped below zero, and its magnitude mirrors the +1024 case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write address |
| wr_data_i | input | 16 | Register write data (phase step) |
| in_valid_i | input | 1 | Input sample valid |
| in_i_i | input | 16 | Input in-phase sample, signed |
| in_q_i | input | 16 | Input quadrature sample, signed |
| out_valid_o | output | 1 | Output sample valid |
| out_i_o | output | 16 | Rotated in-phase sample, signed |
| out_q_o | output | 16 | Rotated quadrature sample, signed |

## Verification
The hardest case to reach is a change of step in the middle of a stream. It must be shown that the phase carries on from where it was, and that the accumulator wraps below zero so the rotation reverses. The stimulus first runs the step at +1024 with a constant (16384, 0) input. It then writes 0xFC00 and walks the phase back through zero, comparing every output against a model phase that was never reset. Saturation needs the table's 45° entry under full-scale inputs, so the stimulus resets, parks the accumulator at 8192 and then sets the step to 0.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // Rounded, clamped table coefficient for index k of a 2^idx_w entry table
  function automatic int lut_coef(int k, int idx_w, int coef_w, bit use_sin);
    real ang, v;
    int r, lim;
    ang = TWO_PI * real'(k) / real'(1 << idx_w);
    v   = (use_sin ? $sin(ang) : $cos(ang)) * (2.0 ** (coef_w - 1));
    r   = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    lim = (1 << (coef_w - 1)) - 1;
    if (r > lim) r = lim;
    if (r < -lim - 1) r = -lim - 1;
    return r;
  endfunction
endpackage

// File: rtl/cfo_phase_gen.sv
module cfo_phase_gen #(
  parameter int PH_W = 16,
  parameter int IDX_W = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] INC_ADDR = 12'h118
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PH_W-1:0]   wr_data_i,
  input  logic              adv_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [PH_W-1:0]   step_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [PH_W-1:0] phase_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      step_q  <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == INC_ADDR) step_q <= wr_data_i;
      if (adv_i) phase_q <= phase_q + step_q;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign idx_o   = phase_q[PH_W-1 -: IDX_W];
endmodule

// File: rtl/cfo_nco_lut.sv
module cfo_nco_lut #(
  parameter int IDX_W = 8,
  parameter int COEF_W = 16
) (
  input  logic [IDX_W-1:0]         idx_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic signed [COEF_W-1:0] cos_tab [DEPTH];
  logic signed [COEF_W-1:0] sin_tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    assign cos_tab[g] = COEF_W'(cfo_pkg::lut_coef(g, IDX_W, COEF_W, 1'b0));
    assign sin_tab[g] = COEF_W'(cfo_pkg::lut_coef(g, IDX_W, COEF_W, 1'b1));
  end

  assign cos_o = cos_tab[idx_i];
  assign sin_o = sin_tab[idx_i];
endmodule

// File: rtl/cfo_cmul.sv
module cfo_cmul #(
  parameter int SMP_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [SMP_W-1:0]  re_i,
  input  logic signed [SMP_W-1:0]  im_i,
  input  logic signed [COEF_W-1:0] cos_i,
  input  logic signed [COEF_W-1:0] sin_i,
  output logic                     valid_o,
  output logic signed [SMP_W-1:0]  re_o,
  output logic signed [SMP_W-1:0]  im_o
);
  localparam int PROD_W = SMP_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] RND  = PROD_W'(1) <<< (COEF_W - 2);
  localparam logic signed [PROD_W-1:0] SMAX = {{(PROD_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] SMIN = {{(PROD_W-SMP_W+1){1'b1}}, {(SMP_W-1){1'b0}}};

  function automatic logic signed [SMP_W-1:0] sat(input logic signed [PROD_W-1:0] x);
    if (x > SMAX) return SMAX[SMP_W-1:0];
    if (x < SMIN) return SMIN[SMP_W-1:0];
    return x[SMP_W-1:0];
  endfunction

  logic                     v1_q;
  logic signed [SMP_W-1:0]  a_re_q, a_im_q;
  logic signed [COEF_W-1:0] c_q, s_q;
  logic signed [PROD_W-1:0] re_sum, im_sum, re_sh, im_sh;

  // Stage 1: capture sample with its coefficients
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      a_re_q <= '0; a_im_q <= '0; c_q <= '0; s_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        a_re_q <= re_i; a_im_q <= im_i; c_q <= cos_i; s_q <= sin_i;
      end
    end
  end

  always_comb begin
    re_sum = PROD_W'(a_re_q) * PROD_W'(c_q) - PROD_W'(a_im_q) * PROD_W'(s_q);
    im_sum = PROD_W'(a_re_q) * PROD_W'(s_q) + PROD_W'(a_im_q) * PROD_W'(c_q);
    re_sh  = (re_sum + RND) >>> (COEF_W - 1);
    im_sh  = (im_sum + RND) >>> (COEF_W - 1);
  end

  // Stage 2: round, saturate, register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      re_o <= '0; im_o <= '0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) begin
        re_o <= sat(re_sh);
        im_o <= sat(im_sh);
      end
    end
  end
endmodule

// File: rtl/cfo_rotator.sv
module cfo_rotator #(
  parameter int PH_W = 16,
  parameter int IDX_W = 8,
  parameter int SMP_W = 16,
  parameter int COEF_W = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] INC_ADDR = 12'h118
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [PH_W-1:0]         wr_data_i,
  input  logic                    in_valid_i,
  input  logic signed [SMP_W-1:0] in_i_i,
  input  logic signed [SMP_W-1:0] in_q_i,
  output logic                    out_valid_o,
  output logic signed [SMP_W-1:0] out_i_o,
  output logic signed [SMP_W-1:0] out_q_o
);
  logic [PH_W-1:0]          phase_q, step_q;
  logic [IDX_W-1:0]         idx;
  logic signed [COEF_W-1:0] cos_v, sin_v;

  cfo_phase_gen #(.PH_W(PH_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .INC_ADDR(INC_ADDR)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .adv_i(in_valid_i),
    .phase_o(phase_q), .step_o(step_q), .idx_o(idx)
  );

  cfo_nco_lut #(.IDX_W(IDX_W), .COEF_W(COEF_W)) u_lut (
    .idx_i(idx), .cos_o(cos_v), .sin_o(sin_v)
  );

  cfo_cmul #(.SMP_W(SMP_W), .COEF_W(COEF_W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(in_valid_i), .re_i(in_i_i), .im_i(in_q_i),
    .cos_i(cos_v), .sin_i(sin_v),
    .valid_o(out_valid_o), .re_o(out_i_o), .im_o(out_q_o)
  );
endmodule

// File: rtl/cfo_rotator_chk.sv
module cfo_rotator_chk #(
  parameter int PH_W = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] INC_ADDR = 12'h118
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [PH_W-1:0]   wr_data_i,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic [PH_W-1:0]   phase_q,
  input logic [PH_W-1:0]   step_q
);
  logic [1:0] age;
  logic       hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign hit = wr_en_i && (wr_addr_i == INC_ADDR);

  p_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(phase_q));

  p_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (phase_q == PH_W'($past(phase_q) + $past(step_q))));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (step_q == $past(wr_data_i)));

  p_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(step_q));
endmodule

bind cfo_rotator cfo_rotator_chk #(.PH_W(PH_W), .ADDR_W(ADDR_W), .INC_ADDR(INC_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .in_valid_i(in_valid_i), .out_valid_o(out_valid_o),
  .phase_q(phase_q), .step_q(step_q)
);

// File: tb/sim_cfo_rotator.sv
`timescale 1ns/1ps
module sim_cfo_rotator;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #4 clk = ~clk;

  cfo_rotator u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .in_valid_i(in_valid), .in_i_i(in_i), .in_q_i(in_q),
    .out_valid_o(out_valid), .out_i_o(out_i), .out_q_o(out_q)
  );

  int n_chk = 0, n_err = 0;
  int ctab[256], stab[256];
  int m_phase = 0, m_inc = 0;
  bit e1_v = 0, e2_v = 0;
  int e1_re = 0, e1_im = 0, e2_re = 0, e2_im = 0, h_re = 0, h_im = 0;
  bit a_v;
  int a_re, a_im;

  function automatic int tcoef(int k, bit s);
    real v;
    int r;
    v = (s ? $sin(6.283185307179586 * k / 256.0) : $cos(6.283185307179586 * k / 256.0)) * 32768.0;
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int rsat(longint x);
    longint y;
    y = (x + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  function automatic int rot_re(int i, int q, int ph);
    int k = (ph >> 8) & 255;
    return rsat(longint'(i) * ctab[k] - longint'(q) * stab[k]);
  endfunction

  function automatic int rot_im(int i, int q, int ph);
    int k = (ph >> 8) & 255;
    return rsat(longint'(i) * stab[k] + longint'(q) * ctab[k]);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: compare outputs, advance the model, drive new inputs
  task automatic step(bit v, int i = 0, int q = 0, bit we = 0, int addr = 0, int data = 0);
    @(negedge clk);
    a_v = out_valid; a_re = out_i; a_im = out_q;
    if (e2_v) begin h_re = e2_re; h_im = e2_im; end
    chk(a_v == e2_v, "R8 valid", a_v, e2_v);
    chk(a_re == h_re, "R6 out_i", a_re, h_re);
    chk(a_im == h_im, "R6 out_q", a_im, h_im);
    e2_v = e1_v; e2_re = e1_re; e2_im = e1_im;
    e1_v = v;
    if (v) begin
      e1_re = rot_re(i, q, m_phase);
      e1_im = rot_im(i, q, m_phase);
      m_phase = (m_phase + m_inc) & 16'hffff;
    end
    if (we && addr == 'h118) m_inc = data & 16'hffff;
    in_valid = v; in_i = 16'(i); in_q = 16'(q);
    wr_en = we; wr_addr = 12'(addr); wr_data = 16'(data);
  endtask

  task automatic send(int i, int q);
    step(1, i, q);
    step(0);
    step(0);
  endtask

  task automatic wr(int addr, int data);
    step(0, 0, 0, 1, addr, data);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; in_valid = 0; wr_en = 0; in_i = 0; in_q = 0;
    m_phase = 0; m_inc = 0; e1_v = 0; e2_v = 0; h_re = 0; h_im = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_i == 0 && out_q == 0, "R1 in reset", int'(out_valid), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int s1_im, s2_re, s2_im, p0;
    int lcg = 7, nv = 0, nout = 0;
    for (int k = 0; k < 256; k++) begin ctab[k] = tcoef(k, 0); stab[k] = tcoef(k, 1); end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(0);
    chk(a_v == 0 && a_re == 0 && a_im == 0, "R1 after reset", a_re, 0);

    // R7: zero step passes samples unchanged
    send(1000, -2000);
    chk(a_re == 1000 && a_im == -2000, "R7 pass", a_re, 1000);
    send(16384, -16383);
    chk(a_re == 16384 && a_im == -16383, "R7 edge", a_im, -16383);
    send(-16383, 16384);
    chk(a_re == -16383 && a_im == 16384, "R7 edge2", a_re, -16383);

    // R2 / R10: +1024 step
    wr('h118, 1024);
    send(16384, 0);
    chk(a_re == 16384 && a_im == 0, "R5 index0", a_re, 16384);
    send(16384, 0);
    s1_im = a_im;
    chk(a_im > 0, "R10 positive", a_im, 1);

    // R9: switch to -1024 mid-stream, phase continues from 2048
    wr('h118, 'hFC00);
    send(16384, 0);
    chk(a_im == rot_im(16384, 0, 2048) && a_im > s1_im, "R9 continuity", a_im, rot_im(16384, 0, 2048));
    send(16384, 0);
    chk(a_im == s1_im, "R9 back at 1024", a_im, s1_im);
    send(16384, 0);
    chk(a_im == 0, "R3 at zero", a_im, 0);
    send(16384, 0);
    chk(a_im < 0 && a_im == -s1_im, "R10 negative", a_im, -s1_im);

    // R2: write to another address is ignored
    wr('h11C, 5);
    p0 = m_phase;
    send(16384, 0);
    chk(a_im == rot_im(16384, 0, 63488) && p0 == 63488, "R2 ignored", a_im, rot_im(16384, 0, 63488));

    // R4: low phase bits do not change the index
    wr('h118, 'h0080);
    send(12000, -7000);
    s2_re = a_re; s2_im = a_im;
    send(12000, -7000);
    chk(a_re == s2_re && a_im == s2_im, "R4 same index", a_re, s2_re);
    send(12000, -7000);
    chk(a_re != s2_re || a_im != s2_im, "R4 next index", a_re, s2_re);

    // R5: quarter-turn steps
    do_reset();
    step(0);
    chk(a_v == 0 && a_re == 0 && a_im == 0, "R1 re-reset", a_re, 0);
    wr('h118, 16384);
    send(16384, 0);
    send(16384, 0);
    chk(a_re == 0 && a_im == 16384, "R5 90deg", a_im, 16384);
    send(16384, 0);
    chk(a_re == -16384 && a_im == 0, "R5 180deg", a_re, -16384);
    send(16384, 0);
    chk(a_re == 0 && a_im == -16384, "R5 270deg", a_im, -16384);

    // R6: saturation at 45 degrees
    wr('h118, 8192);
    send(0, 0);
    wr('h118, 0);
    send(32767, 32767);
    chk(a_im == 32767, "R6 sat high", a_im, 32767);
    send(-32768, -32768);
    chk(a_im == -32768, "R6 sat low", a_im, -32768);

    // R8: dense stream with gaps, model compared every cycle
    wr('h118, 300);
    for (int n = 0; n < 600; n++) begin
      bit v;
      lcg = lcg * 1103515245 + 12345;
      v = lcg[20] | lcg[9];
      nv += v;
      step(v, (lcg >>> 8) % 32768, (lcg >>> 3) % 32768);
      nout += a_v;
    end
    step(0); nout += a_v;
    step(0); nout += a_v;
    chk(nout + int'(e1_v) + int'(e2_v) == nv, "R8 count", nout, nv);
    step(0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule